// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Flag

The block compares a reference comparison pulse train against the divided oscillator pulse train, both sampled on a fast system clock. A rising edge on the reference arms an "up" request and a rising edge on the divided feedback arms a "down" request. As soon as both requests are armed, they are cleared together. The width of each request pulse is therefore the phase error, and a missing edge on one side shows up as a frequency error. The up/down pair drives an external charge pump. The pump output has its own output enable, so it can be tri-stated. A current-select level is passed on to the pump, and a drive-enable output lets the varactor drive be switched off so that an external alignment voltage can be applied.

A lock monitor measures every comparison cycle in system clocks. After a run of consecutive short cycles it declares lock. The lock flag is modelled as an open-drain pin: the value is always low, and the output enable is asserted while the loop is out of lock. A released (high-impedance) pin therefore means the loop is locked. In test mode, two port outputs carry the feedback train halved and the sampled reference instead of their programmed values.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset, pump_up_o and pump_dn_o are 0, lock_oe_o is 1 (not locked), and the halved-feedback toggle is 0.
- R2: A rising edge on ref_i makes pump_up_o go high on the second clock edge after ref_i is sampled high.
- R3: A rising edge on fb_i makes pump_dn_o go high on the second clock edge after fb_i is sampled high.
- R4: When pump_up_o and pump_dn_o are both high, both fall on the next edge unless a new edge on the matching input arrives in that cycle.
- R5: pump_oe_o is the inverse of pump_off_i, and pump_off_i does not change pump_up_o or pump_dn_o.
- R6: pump_hi_o follows pump_hi_i, and drive_en_o is the inverse of drive_off_i.
- R7: A comparison cycle is good when up or down has been high for at most LOCK_WIN clocks, counting through the cycle in which both are high. After LOCK_CYCLES consecutive good cycles (default 16, with LOCK_WIN = 3), lock_oe_o goes to 0.
- R8: The first clock in which an up or down pulse exceeds LOCK_WIN clocks clears the run count, and lock_oe_o returns to 1 on the next edge.
- R9: pump_off_i and drive_off_i have no effect on lock detection.
- R10: With test_mode_i = 1, port_o[0] is a toggle that flips once per sampled rising edge of fb_i, and port_o[1] is the sampled ref_i level. With test_mode_i = 0, port_o equals port_val_i, with bit 0 on port 0.
- R11: lock_o is always 0; only lock_oe_o carries the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Comparison reference pulse train |
| fb_i | input | 1 | Divided oscillator pulse train |
| pump_off_i | input | 1 | Tri-states the pump output |
| pump_hi_i | input | 1 | Pump current level select |
| drive_off_i | input | 1 | Switches the varactor drive off |
| test_mode_i | input | 1 | Routes test signals to the ports |
| port_val_i | input | 2 | Programmed port values |
| pump_up_o | output | 1 | Pump up request |
| pump_dn_o | output | 1 | Pump down request |
| pump_oe_o | output | 1 | Pump output enable |
| pump_hi_o | output | 1 | Pump current level |
| drive_en_o | output | 1 | Varactor drive enable |
| lock_o | output | 1 | Lock pin value (always low) |
| lock_oe_o | output | 1 | Lock pin enable; 1 means out of lock |
| port_o | output | 2 | Port outputs |

## Verification
A request flop that is stuck or cleared at the wrong time is visible on pump_up_o or pump_dn_o within two clocks of the next input edge. A wrong pulse-width count or a wrong run counter only shows on lock_oe_o. That happens at the end of the sixteenth comparison cycle, or in the first over-long cycle, so each stimulus segment is long enough for several full lock and unlock transitions. A toggle that misses a feedback edge leaves port_o[0] wrong for the rest of a test-mode window. That error is visible within one feedback period.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned DEF_LOCK_WIN    = 3;
  localparam int unsigned DEF_LOCK_CYCLES = 16;
  localparam int unsigned PORT_W          = 2;
  localparam int unsigned N_EDGE          = 2;
  localparam int unsigned CH_REF          = 0;
  localparam int unsigned CH_FB           = 1;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;
endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_no = s2_q;
endmodule

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense (
  input  logic clk,
  input  logic rst_ni,
  input  logic sig_i,
  output logic level_o,
  output logic rise_o
);
  logic cur_q, old_q;
  logic cur_d, old_d;

  always_comb begin
    cur_d = sig_i;
    old_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= 1'b0;
      old_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      old_q <= old_d;
    end
  end

  assign level_o = cur_q;
  assign rise_o  = cur_q & ~old_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      ref_rise_i,
  input  logic      fb_rise_i,
  output pump_req_t req_o,
  output logic      clr_o
);
  pump_req_t req_q, req_d;
  logic      clr;

  always_comb begin
    clr       = req_q.up & req_q.dn;
    req_d.up  = (req_q.up & ~clr) | ref_rise_i;
    req_d.dn  = (req_q.dn & ~clr) | fb_rise_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;
  assign clr_o = clr;
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned LOCK_WIN    = 3,
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  input  logic clr_i,
  output logic locked_o
);
  localparam int unsigned WW = $clog2(LOCK_WIN + 2);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [WW-1:0] WIN_V = WW'(LOCK_WIN);
  localparam logic [WW-1:0] SAT_V = WW'(LOCK_WIN + 1);
  localparam logic [CW-1:0] RUN_V = CW'(LOCK_CYCLES);

  logic [WW-1:0] wid_q, wid_d, wid_plus;
  logic [CW-1:0] run_q, run_d;
  logic          active, too_long, run_en, wid_en;

  always_comb begin
    active   = up_i | dn_i;
    wid_plus = wid_q + WW'(1);
    too_long = active && (wid_plus > WIN_V);
    // width counter: counts request clocks of the current comparison cycle
    wid_en = active || (wid_q != '0);
    wid_d  = wid_q;
    if (!active || clr_i)      wid_d = '0;
    else if (wid_plus > SAT_V) wid_d = SAT_V;
    else                       wid_d = wid_plus;
    // run counter of consecutive good comparison cycles
    run_en = too_long || (clr_i && run_q != RUN_V);
    run_d  = run_q;
    if (too_long)   run_d = '0;
    else if (clr_i) run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     wid_q <= '0;
    else if (wid_en) wid_q <= wid_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign locked_o = (run_q == RUN_V);
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int unsigned LOCK_WIN    = DEF_LOCK_WIN,
  parameter int unsigned LOCK_CYCLES = DEF_LOCK_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_i,
  input  logic              fb_i,
  input  logic              pump_off_i,
  input  logic              pump_hi_i,
  input  logic              drive_off_i,
  input  logic              test_mode_i,
  input  logic [PORT_W-1:0] port_val_i,
  output logic              pump_up_o,
  output logic              pump_dn_o,
  output logic              pump_oe_o,
  output logic              pump_hi_o,
  output logic              drive_en_o,
  output logic              lock_o,
  output logic              lock_oe_o,
  output logic [PORT_W-1:0] port_o
);
  logic              rst_int_n;
  logic [N_EDGE-1:0] in_vec, lvl_vec, rise_vec;
  pump_req_t         req;
  logic              clr, locked;
  logic              half_q, half_d, half_en;

  pfd_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_int_n));

  always_comb begin
    in_vec         = '0;
    in_vec[CH_REF] = ref_i;
    in_vec[CH_FB]  = fb_i;
  end

  for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
    pfd_edge_sense u_es (
      .clk    (clk),
      .rst_ni (rst_int_n),
      .sig_i  (in_vec[g]),
      .level_o(lvl_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  pfd_core u_core (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .ref_rise_i(rise_vec[CH_REF]),
    .fb_rise_i (rise_vec[CH_FB]),
    .req_o     (req),
    .clr_o     (clr)
  );

  pfd_lock_mon #(.LOCK_WIN(LOCK_WIN), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .up_i    (req.up),
    .dn_i    (req.dn),
    .clr_i   (clr),
    .locked_o(locked)
  );

  // feedback halved for the test route
  always_comb begin
    half_en = rise_vec[CH_FB];
    half_d  = ~half_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   half_q <= 1'b0;
    else if (half_en) half_q <= half_d;
  end

  always_comb begin
    pump_up_o  = req.up;
    pump_dn_o  = req.dn;
    pump_oe_o  = ~pump_off_i;
    pump_hi_o  = pump_hi_i;
    drive_en_o = ~drive_off_i;
    lock_o     = 1'b0;
    lock_oe_o  = ~locked;
    port_o     = port_val_i;
    if (test_mode_i) begin
      port_o[0] = half_q;
      port_o[1] = lvl_vec[CH_REF];
    end
  end
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_rise,
  input logic       fb_rise,
  input logic       pump_up_o,
  input logic       pump_dn_o,
  input logic       lock_oe_o,
  input logic       test_mode_i,
  input logic [1:0] port_o
);
  p_up_follows_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> pump_up_o);

  p_dn_follows_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rise |=> pump_dn_o);

  p_overlap_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up_o && pump_dn_o && !ref_rise) |=> !pump_up_o);

  p_overlap_clears_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up_o && pump_dn_o && !fb_rise) |=> !pump_dn_o);

  p_lock_only_at_cycle_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_oe_o) |-> $past(pump_up_o && pump_dn_o));

  p_half_toggles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fb_rise) && test_mode_i && $past(test_mode_i)) |-> (port_o[0] != $past(port_o[0])));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_rise   (rise_vec[0]),
  .fb_rise    (rise_vec[1]),
  .pump_up_o  (pump_up_o),
  .pump_dn_o  (pump_dn_o),
  .lock_oe_o  (lock_oe_o),
  .test_mode_i(test_mode_i),
  .port_o     (port_o)
);

// File: tb/pfd_lock_top_tb_top.sv
module pfd_lock_top_tb_top;
  localparam int WIN  = 3;
  localparam int NCYC = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_i, fb_i, pump_off_i, pump_hi_i, drive_off_i, test_mode_i;
  logic [1:0] port_val_i;
  logic pump_up_o, pump_dn_o, pump_oe_o, pump_hi_o, drive_en_o, lock_o, lock_oe_o;
  logic [1:0] port_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tstep = 0;

  // requirement-level reference state
  int m_r1, m_r2, m_f1, m_f2, m_up, m_dn, m_w, m_run, m_half;

  always #2.5 clk = ~clk;

  pfd_lock_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fb_i(fb_i),
    .pump_off_i(pump_off_i), .pump_hi_i(pump_hi_i), .drive_off_i(drive_off_i),
    .test_mode_i(test_mode_i), .port_val_i(port_val_i),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_oe_o(pump_oe_o),
    .pump_hi_o(pump_hi_o), .drive_en_o(drive_en_o), .lock_o(lock_o),
    .lock_oe_o(lock_oe_o), .port_o(port_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_port(input int bitn);
    if (test_mode_i) return (bitn == 0) ? m_half : m_r1;
    return int'(port_val_i[bitn]);
  endfunction

  task automatic model_update();
    int rr, fr, clr, act, wp, bad;
    rr  = m_r1 & ~m_r2 & 1;
    fr  = m_f1 & ~m_f2 & 1;
    clr = m_up & m_dn;
    act = m_up | m_dn;
    wp  = m_w + 1;
    bad = act && (wp > WIN);
    if (bad) m_run = 0;
    else if (clr && m_run != NCYC) m_run++;
    if (!act || clr) m_w = 0;
    else m_w = (wp > WIN + 1) ? WIN + 1 : wp;
    m_up = (m_up & ~clr & 1) | rr;
    m_dn = (m_dn & ~clr & 1) | fr;
    if (fr) m_half ^= 1;
    m_r2 = m_r1; m_r1 = int'(ref_i);
    m_f2 = m_f1; m_f1 = int'(fb_i);
  endtask

  task automatic compare();
    check("R2 R4 pump_up", int'(pump_up_o), m_up);
    check("R3 R4 pump_dn", int'(pump_dn_o), m_dn);
    check("R5 pump_oe", int'(pump_oe_o), int'(!pump_off_i));
    check("R6 pump_hi", int'(pump_hi_o), int'(pump_hi_i));
    check("R6 drive_en", int'(drive_en_o), int'(!drive_off_i));
    check("R7 R8 lock_oe", int'(lock_oe_o), (m_run == NCYC) ? 0 : 1);
    check("R11 lock_o", int'(lock_o), 0);
    check("R10 port0", int'(port_o[0]), exp_port(0));
    check("R10 port1", int'(port_o[1]), exp_port(1));
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int rp, input int fp, input int off, input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      ref_i = ((tstep % rp) < rp / 2);
      fb_i  = (((tstep + off) % fp) < fp / 2);
      tstep++;
      if (rnd) begin
        if ($urandom_range(15) == 0) pump_off_i  = ~pump_off_i;
        if ($urandom_range(15) == 0) drive_off_i = ~drive_off_i;
        if ($urandom_range(15) == 0) pump_hi_i   = ~pump_hi_i;
        if ($urandom_range(31) == 0) test_mode_i = ~test_mode_i;
        if ($urandom_range(7) == 0)  port_val_i  = 2'($urandom_range(3));
      end
      tick();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    ref_i = 0; fb_i = 0; pump_off_i = 0; pump_hi_i = 0; drive_off_i = 0;
    test_mode_i = 0; port_val_i = 2'b10;
    m_r1 = 0; m_r2 = 0; m_f1 = 0; m_f2 = 0; m_up = 0; m_dn = 0;
    m_w = 0; m_run = 0; m_half = 0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 pump_up", int'(pump_up_o), 0);
    check("R1 pump_dn", int'(pump_dn_o), 0);
    check("R1 lock_oe", int'(lock_oe_o), 1);
    test_mode_i = 1;
    #1 check("R1 half toggle", int'(port_o[0]), 0);
    test_mode_i = 0;

    // aligned edges: lock expected (R7)
    run(16, 16, 0, 400, 0);
    check("R7 locked after aligned run", int'(lock_oe_o), 0);
    // wide phase error: unlock (R8)
    run(16, 16, 6, 40, 0);
    check("R8 unlock on wide pulse", int'(lock_oe_o), 1);
    // relock with pump and drive disabled (R9)
    pump_off_i = 1; drive_off_i = 1;
    run(16, 16, 1, 400, 0);
    check("R9 lock unaffected by disables", int'(lock_oe_o), 0);
    check("R5 pump tri-stated", int'(pump_oe_o), 0);
    pump_off_i = 0;
    run(16, 16, 1, 40, 0);
    check("R9 lock kept after pump enable", int'(lock_oe_o), 0);
    drive_off_i = 0;
    // frequency error: unlock (R8)
    run(16, 13, 0, 200, 0);
    check("R8 unlock on frequency error", int'(lock_oe_o), 1);
    // test routing (R10)
    test_mode_i = 1;
    run(12, 12, 0, 120, 0);
    test_mode_i = 0;
    // random segments
    for (int s = 0; s < 24; s++) begin
      int rp, fp, off;
      rp  = 8 + $urandom_range(16);
      fp  = ($urandom_range(1) == 0) ? rp : rp + 1 - $urandom_range(2);
      off = $urandom_range(rp - 1);
      run(rp, fp, off, 300, 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule